// File: doc/BRIEF.md
# Streaming Overlap-Add Recombiner

This block rebuilds a continuous sample stream from a sequence of fixed-length blocks, each of which is the inverse-transform output of a fast block correlation. Every block holds N = L + M - 1 real samples. The front M - 1 samples of a block overlap the back M - 1 samples of the block before it, so they are added to a stored tail. The next samples are released unchanged up to position L - 1. The final M - 1 samples are held back as the tail for the following block. Each block therefore yields exactly L output samples.

Two tail banks work in ping-pong fashion. The incoming block reads the bank filled by the previous block while it writes its own tail into the other bank. The banks trade roles when a block closes with the correct length, so a stream of blocks with no gaps between them runs with no bubbles. Sums clip to the signed output range. A block that closes at any length other than N raises a one-cycle error pulse, and its tail is dropped.

The input is a valid/ready stream marked with a last flag. Once reset is released, in_ready stays high, so the block never applies back-pressure and takes one sample on every cycle that in_valid is high. The output stream carries no ready signal, and the downstream logic must accept every beat on which out_valid is high. Parameters: BLK_L (L), OVL_M (M, at least 2, no larger than L + 1), DW input width, OW output width (OW at least DW).

Top module: `oa_accum_top`

## Requirements
- R1: During reset, in_ready, out_valid and blk_err are low, and both tail banks are cleared. From the first clock after reset, in_ready is high and stays high. The first block after reset is summed with zeros.
- R2: A sample accepted at block position k < M-1 produces out_data = sat(in_data + tail[k]) with out_valid high on the following clock.
- R3: A sample at position k with M-1 <= k < L is sent out unchanged (sign-extended to OW) on the following clock.
- R4: Samples at positions L to N-1 produce no output. The sample at position k is stored as tail entry k-L for the next block.
- R5: Each well-formed block gives exactly L output beats, each one cycle after its input beat, in input order.
- R6: Sums clip to the largest or smallest signed OW-bit value and never wrap.
- R7: Blocks may follow one another with no gap. The tail each block reads is the one written by the well-formed block just before it.
- R8: When in_last arrives at a position other than N-1, blk_err goes high for exactly one cycle, on the clock after that beat. blk_err stays low on every well-formed block.
- R9: After a block that closed with the wrong length, the next block is summed with a zero tail.
- R10: Cycles with in_valid low produce no output and do not advance the block position. A block may contain gaps.
- R11: In a block that runs past N samples, the extra samples are neither sent out nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | High every cycle after reset; the block never stalls |
| in_data | input | DW | Signed input sample |
| in_last | input | 1 | Marks the final sample of a block |
| out_valid | output | 1 | Output sample valid; it cannot be stalled |
| out_data | output | OW | Signed recombined sample |
| blk_err | output | 1 | One-cycle pulse for a block closed at the wrong length |

## Verification
The bench runs back-to-back blocks and blocks with idle gaps to show that the ping-pong banks hand each block the correct tail. A swap made one block early or late would add a stale tail, and the sums in positions 0 to M-2 would then be wrong. Positive and negative overflows check saturation; a design that wraps would flip the sign of those outputs. A short block and an overlong block check the error pulse, the zero tail that follows a bad block and the silence of extra samples. A design that kept a partly written tail, or that sent out samples past N, would show mismatched sums or stray out_valid beats. A reset in the middle of a block checks that the block after it starts from a zero tail.

// File: rtl/oa_pkg.sv
package oa_pkg;
  typedef enum logic [1:0] {
    PH_SUM  = 2'd0,
    PH_PASS = 2'd1,
    PH_TAIL = 2'd2,
    PH_DROP = 2'd3
  } phase_e;
endpackage

// File: rtl/oa_index_ctrl.sv
module oa_index_ctrl
  import oa_pkg::*;
#(
  parameter int BLK_L = 8,
  parameter int OVL_M = 4,
  parameter int IW    = 4,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          beat,
  input  logic          last,
  output phase_e        phase,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic          swap,
  output logic          bad_end,
  output logic          err_q
);
  localparam int BLK_N = BLK_L + OVL_M - 1;
  localparam logic [IW-1:0] TD_I   = IW'(OVL_M - 1);
  localparam logic [IW-1:0] L_I    = IW'(BLK_L);
  localparam logic [IW-1:0] N_I    = IW'(BLK_N);
  localparam logic [IW-1:0] LAST_I = IW'(BLK_N - 1);

  logic [IW-1:0] idx_q;
  logic [IW-1:0] tail_off;

  always_comb begin
    if (idx_q < TD_I)      phase = PH_SUM;
    else if (idx_q < L_I)  phase = PH_PASS;
    else if (idx_q < N_I)  phase = PH_TAIL;
    else                   phase = PH_DROP;
  end

  assign tail_off = idx_q - L_I;
  assign rd_addr  = idx_q[AW-1:0];
  assign wr_addr  = tail_off[AW-1:0];
  assign swap     = beat && last && (idx_q == LAST_I);
  assign bad_end  = beat && last && (idx_q != LAST_I);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= bad_end;
      if (beat) begin
        if (last)             idx_q <= '0;
        else if (idx_q < N_I) idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/oa_tail_bank.sv
module oa_tail_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 3,
  parameter int AW    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [DW-1:0] wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic signed [DW-1:0] rd_data,
  input  logic                 swap,
  input  logic                 clear_rd
);
  logic                 rd_sel_q;
  logic signed [DW-1:0] rd_bank [2];

  always_ff @(posedge clk) begin
    if (rst)       rd_sel_q <= 1'b0;
    else if (swap) rd_sel_q <= ~rd_sel_q;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic signed [DW-1:0] mem_q [DEPTH];
    logic is_rd;
    assign is_rd = (rd_sel_q == 1'(b));

    always_ff @(posedge clk) begin
      if (rst || (clear_rd && is_rd)) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_en && !is_rd && (32'(wr_addr) < DEPTH)) begin
        mem_q[wr_addr] <= wr_data;
      end
    end

    assign rd_bank[b] = (32'(rd_addr) < DEPTH) ? mem_q[rd_addr] : '0;
  end

  assign rd_data = rd_bank[rd_sel_q];
endmodule

// File: rtl/oa_sat_add.sv
module oa_sat_add #(
  parameter int DW = 16,
  parameter int OW = 16
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [OW-1:0] y
);
  localparam int SW = (DW + 1 > OW) ? DW + 1 : OW;
  localparam logic signed [SW-1:0] MAXV = {{(SW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = ~MAXV;

  logic signed [SW-1:0] sum;

  always_comb begin
    sum = SW'(a) + SW'(b);
    if (sum > MAXV)      y = MAXV[OW-1:0];
    else if (sum < MINV) y = MINV[OW-1:0];
    else                 y = sum[OW-1:0];
  end
endmodule

// File: rtl/oa_accum_top.sv
module oa_accum_top
  import oa_pkg::*;
#(
  parameter int BLK_L = 8,
  parameter int OVL_M = 4,
  parameter int DW    = 16,
  parameter int OW    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  input  logic                 in_last,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data,
  output logic                 blk_err
);
  localparam int BLK_N  = BLK_L + OVL_M - 1;
  localparam int TAIL_D = OVL_M - 1;
  localparam int IW     = $clog2(BLK_N + 1);
  localparam int AW     = (TAIL_D > 1) ? $clog2(TAIL_D) : 1;

  phase_e               phase;
  logic [AW-1:0]        rd_addr, wr_addr;
  logic                 swap, bad_end, beat, emit;
  logic signed [DW-1:0] tail_rd, addend;
  logic signed [OW-1:0] sum_y;

  always_ff @(posedge clk) begin
    if (rst) in_ready <= 1'b0;
    else     in_ready <= 1'b1;
  end

  assign beat = in_valid && in_ready;
  assign emit = beat && ((phase == PH_SUM) || (phase == PH_PASS));

  oa_index_ctrl #(.BLK_L(BLK_L), .OVL_M(OVL_M), .IW(IW), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .beat(beat), .last(in_last),
    .phase(phase), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .swap(swap), .bad_end(bad_end), .err_q(blk_err)
  );

  oa_tail_bank #(.DW(DW), .DEPTH(TAIL_D), .AW(AW)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(beat && (phase == PH_TAIL)), .wr_addr(wr_addr), .wr_data(in_data),
    .rd_addr(rd_addr), .rd_data(tail_rd),
    .swap(swap), .clear_rd(bad_end)
  );

  assign addend = (phase == PH_SUM) ? tail_rd : '0;

  oa_sat_add #(.DW(DW), .OW(OW)) u_add (.a(in_data), .b(addend), .y(sum_y));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      if (emit) out_data <= sum_y;
    end
  end
endmodule

// File: rtl/oa_accum_chk.sv
module oa_accum_chk #(
  parameter int BLK_L = 8,
  parameter int OVL_M = 4,
  parameter int DW    = 16,
  parameter int OW    = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic signed [DW-1:0] in_data,
  input logic                 in_last,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_data,
  input logic                 blk_err
);
  localparam int BLK_N = BLK_L + OVL_M - 1;
  localparam int IW    = $clog2(BLK_N + 1);

  logic [IW-1:0] pos_q;
  logic          acc;
  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else if (acc) begin
      if (in_last)                 pos_q <= '0;
      else if (32'(pos_q) < BLK_N) pos_q <= pos_q + 1'b1;
    end
  end

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);

  // R5
  out_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(acc));

  // R4
  tail_silent_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(32'(pos_q) < BLK_L));

  // R3
  pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(32'(pos_q) >= OVL_M - 1)) |-> (out_data == OW'($past(in_data))));

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    blk_err |-> $past(acc && in_last));

  // R8
  err_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && in_last && (32'(pos_q) == BLK_N - 1)) |=> !blk_err);
endmodule

bind oa_accum_top oa_accum_chk #(.BLK_L(BLK_L), .OVL_M(OVL_M), .DW(DW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
  .out_data(out_data), .blk_err(blk_err)
);

// File: tb/tb_oa_accum_top.sv
module tb_oa_accum_top;
  localparam int L  = 8;
  localparam int M  = 4;
  localparam int N  = L + M - 1;
  localparam int TD = M - 1;
  localparam int NV = 35;

  // Table beat encoding: {valid, last, data[15:0]}
  localparam logic [17:0] VEC [NV] = '{
    {1'b1,1'b0,16'sd100},  {1'b1,1'b0,16'sd200},  {1'b1,1'b0,16'sd300},
    {1'b1,1'b0,16'sd400},  {1'b1,1'b0,16'sd500},  {1'b1,1'b0,16'sd600},
    {1'b1,1'b0,16'sd700},  {1'b1,1'b0,16'sd800},  {1'b1,1'b0,16'sd900},
    {1'b1,1'b0,16'sd1000}, {1'b1,1'b1,16'sd1100},
    {1'b0,1'b0,16'sd0},
    {1'b1,1'b0,16'sd32000}, {1'b1,1'b0,-16'sd32000}, {1'b1,1'b0,16'sd5},
    {1'b0,1'b0,16'sd77},
    {1'b1,1'b0,16'sd1}, {1'b1,1'b0,16'sd2}, {1'b1,1'b0,16'sd3}, {1'b1,1'b0,16'sd4},
    {1'b1,1'b0,16'sd5}, {1'b1,1'b0,16'sd6}, {1'b1,1'b0,16'sd7}, {1'b1,1'b1,16'sd8},
    {1'b1,1'b0,-16'sd3},  {1'b1,1'b0,-16'sd6},  {1'b1,1'b0,-16'sd9},
    {1'b1,1'b0,-16'sd12}, {1'b1,1'b0,-16'sd15}, {1'b1,1'b0,-16'sd18},
    {1'b1,1'b0,-16'sd21}, {1'b1,1'b0,-16'sd24}, {1'b1,1'b0,-16'sd27},
    {1'b1,1'b0,-16'sd30}, {1'b1,1'b1,-16'sd33}
  };

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [15:0] in_data = '0;
  logic               in_last = 1'b0;
  logic               out_valid;
  logic signed [15:0] out_data;
  logic               blk_err;

  always #2.5 clk = ~clk;

  oa_accum_top #(.BLK_L(L), .OVL_M(M), .DW(16), .OW(16)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_data(out_data), .blk_err(blk_err)
  );

  int    n_vec  = 0;
  int    n_fail = 0;
  int    tail_cur [TD];
  int    tail_nxt [TD];
  int    pos      = 0;
  bit    first_blk = 1'b1;
  bit    after_bad = 1'b0;
  bit    exp_v = 1'b0;
  bit    exp_err = 1'b0;
  int    exp_d = 0;
  string exp_tag = "R1";

  function automatic int sat16(int s);
    if (s > 32767)  return 32767;
    if (s < -32768) return -32768;
    return s;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < TD; i++) begin tail_cur[i] = 0; tail_nxt[i] = 0; end
    pos = 0; first_blk = 1'b1; after_bad = 1'b0;
    exp_v = 1'b0; exp_err = 1'b0; exp_tag = "R1";
  endtask

  task automatic model(bit v, bit l, int d);
    int s;
    exp_v = 1'b0; exp_err = 1'b0; exp_tag = "R10";
    if (v) begin
      if (pos < TD) begin
        s = d + tail_cur[pos];
        exp_v = 1'b1; exp_d = sat16(s);
        exp_tag = after_bad ? "R9" : (first_blk ? "R1 R2" : "R2 R7");
        if (s != exp_d) exp_tag = "R6";
      end else if (pos < L) begin
        exp_v = 1'b1; exp_d = d; exp_tag = "R3 R5";
      end else if (pos < N) begin
        tail_nxt[pos-L] = d; exp_tag = "R4";
      end else begin
        exp_tag = "R11";
      end
      if (l) begin
        exp_err = (pos != N-1);
        for (int i = 0; i < TD; i++) tail_cur[i] = exp_err ? 0 : tail_nxt[i];
        after_bad = exp_err;
        first_blk = 1'b0;
        pos = 0;
      end else if (pos < N) begin
        pos++;
      end
    end
  endtask

  task automatic check_pending();
    check({exp_tag, " out_valid"}, int'(out_valid), int'(exp_v));
    if (exp_v) check({exp_tag, " out_data"}, int'(out_data), exp_d);
    check(exp_err ? "R8 blk_err" : "R8 blk_err idle", int'(blk_err), int'(exp_err));
  endtask

  task automatic step(bit v, bit l, int d);
    @(negedge clk);
    check_pending();
    in_valid = v; in_last = l; in_data = 16'(d);
    model(v, l, d);
  endtask

  task automatic flush();
    @(negedge clk);
    check_pending();
    in_valid = 1'b0; in_last = 1'b0;
    model(1'b0, 1'b0, 0);
  endtask

  task automatic block(int len, int base, int inc);
    for (int k = 0; k < len; k++) step(1'b1, (k == len-1), base + k*inc);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    model_reset();
    // R1: state during reset
    repeat (3) @(negedge clk);
    check("R1 in_ready in reset", int'(in_ready), 0);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 blk_err in reset", int'(blk_err), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 in_ready after reset", int'(in_ready), 1);

    // Table walk: R1 zero tail, R2..R7, R10 gaps, R6 positive clip
    for (int i = 0; i < NV; i++) step(VEC[i][17], VEC[i][16], int'($signed(VEC[i][15:0])));
    flush();

    // R8 short block, then R9 zero tail on the next block
    block(6, 50, 1);
    block(N, 10, 10);
    // R11 overlong block, then R9 again
    block(N + 2, 40, 3);
    block(N, 7, 1);
    // R6 negative clip: tail of -30000 meets -30000
    block(N, -30000, 0);
    block(N, -30000, 0);
    // R7 back-to-back tail handoff with distinct tails
    block(N, 1000, -37);
    block(N, -500, 91);
    flush();

    // R1 mid-block reset
    block(4, 123, 1);
    @(negedge clk);
    check_pending();
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    check("R1 in_ready mid reset", int'(in_ready), 0);
    check("R1 out_valid mid reset", int'(out_valid), 0);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check("R1 in_ready after mid reset", int'(in_ready), 1);
    block(N, 20, 2);
    flush();
    flush();

    finish_run();
  end
endmodule